// File: doc/BRIEF.md
# Converter Operating Mode Controller

This block chooses how a bidirectional single-cell charger's power stage runs. It picks one of three operations: charging the battery from the input, boosting the battery back onto the input rail for an attached accessory, or a high-impedance standby state. A fourth state, charge-configure, idles the stage while a fault is pending and the input supply is still healthy. The block takes the host's register bits and the board pins as its inputs. It also takes flags from the analog protection comparators. Its outputs drive the power-stage sequencer and feed the host-visible status.

The block also handles boost protection. When a boost fault occurs, it stops the boost and latches a 3-bit cause code. It then asks the register bank to clear the host's boost bit and drops back to charge-configure. An overload only counts as a fault once it has lasted a programmable number of 1 kHz ticks. Each fault produces one fixed-length low pulse on the open-drain status output. While the block is charging, it can instead hold that output low as a charge-in-progress indicator.

The controller is a four-state machine: HIZ, CHARGE, CFG (charge-configure) and BOOST. Its transitions are:
- force (any state to HIZ).
- boost_enter (HIZ, CHARGE or CFG to BOOST).
- boost_fault (BOOST to CFG, or to HIZ if the input is under-voltage).
- boost_release (BOOST to the charge-side choice when boost is no longer requested).
- charge_select (among HIZ, CHARGE and CFG from the input and fault conditions).

Top module: `conv_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `op_mode` is HIZ (2'b00), `boost_stat` is 0, `fault_code` is 3'b000, `mode_clr_req` is 0 and `stat_n` is 1.
- R2: A high `hiz_bit` or a high `chg_dis` puts the block in HIZ on the next clock edge. This holds whatever the boost request and fault flags are.
- R3: When no boost is active or entered, the charge side is chosen as follows: HIZ if `vin_uvlo` is 1; otherwise CFG (2'b10) if `chg_fault` is 1 or `fault_code` is nonzero; otherwise CHARGE (2'b01).
- R4: Boost is requested by `mode_bit`=1, or by `otg_use_en`=1 with `otg_pin` equal to `otg_pin_pol`. When boost is entered, `op_mode` is BOOST (2'b11) and `boost_stat` is 1. With `otg_use_en`=0, the pin has no effect.
- R5: Boost is not entered while `bst_out_ov`, `bst_bat_high` or `bst_bat_low` is set. If one of these rises during BOOST, the next edge leaves BOOST for CFG and latches the code. The codes are 001 for output overvoltage, 100 for battery overvoltage, 011 for battery too low and 010 for overload. When several flags are set, the priority follows that same order.
- R6: `bst_overload` becomes a fault on the edge of its 30th `tick_1k` pulse (`OVL_HOLD_TICKS`) seen while it is held high in BOOST. Dropping the flag for one cycle restarts the count.
- R7: After a boost fault, `mode_clr_req` stays at 1 until `mode_bit` reads 0. During that time `mode_bit` does not re-enter boost.
- R8: After an overload fault, boost stays blocked until `flt_clr` is pulsed, even with `mode_bit`=1. `flt_clr` also returns `fault_code` to 000.
- R9: `stat_n` is 0 while `op_mode` is CHARGE and `status_en` is 1. Outside a fault pulse it is 1 in every other case.
- R10: A boost fault or a rising `chg_fault` drives `stat_n` low for exactly `PULSE_CYCLES` (128) clocks, starting after the edge that registers the event. A further event during the pulse does not extend it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle strobe every millisecond |
| mode_bit | input | 1 | Host boost request bit |
| hiz_bit | input | 1 | Host high-impedance bit |
| chg_dis | input | 1 | Charge-disable pin, high forces HIZ |
| otg_pin | input | 1 | Accessory boost request pin |
| otg_pin_pol | input | 1 | Level of `otg_pin` that counts as active |
| otg_use_en | input | 1 | Enables boost requests from `otg_pin` |
| vin_uvlo | input | 1 | Input supply below undervoltage threshold |
| chg_fault | input | 1 | Any charge-side fault present |
| status_en | input | 1 | Enables the charge-in-progress low level on `stat_n` |
| flt_clr | input | 1 | Host clears the latched fault code and overload block |
| bst_out_ov | input | 1 | Boost output overvoltage flag |
| bst_overload | input | 1 | Boost output overload flag (raw) |
| bst_bat_high | input | 1 | Battery overvoltage during boost |
| bst_bat_low | input | 1 | Battery too low for boost |
| op_mode | output | 2 | 00 HIZ, 01 CHARGE, 10 CFG, 11 BOOST |
| mode_clr_req | output | 1 | Request to clear `mode_bit` after a boost fault |
| boost_stat | output | 1 | 1 while in BOOST |
| fault_code | output | 3 | Latched boost fault cause |
| stat_n | output | 1 | Open-drain status, 0 = pulled low |

## Verification
The bench checks the overload window to the exact tick. A counter that is off by one, or one that is not cleared when the flag drops, would end boost on the 29th or 31st tick, or after a broken run. It raises a second charge fault halfway through a pulse to catch a retriggering stretcher, which would hold `stat_n` low past 128 clocks. It leaves `mode_bit` at 1 after a fault to catch a one-shot clear request, which would let the stale bit restart boost. It also sets the overload block and then sets the mode bit again: a block that forgets the overload would boost before `flt_clr`.

// File: rtl/conv_mode_pkg.sv
package conv_mode_pkg;

    typedef enum logic [1:0] {
        MD_HIZ    = 2'b00,
        MD_CHARGE = 2'b01,
        MD_CFG    = 2'b10,
        MD_BOOST  = 2'b11
    } opmode_e;

    localparam int FC_W = 3;

    localparam logic [FC_W-1:0] FC_NONE     = 3'b000;
    localparam logic [FC_W-1:0] FC_OUT_OV   = 3'b001;
    localparam logic [FC_W-1:0] FC_OVERLOAD = 3'b010;
    localparam logic [FC_W-1:0] FC_BAT_LOW  = 3'b011;
    localparam logic [FC_W-1:0] FC_BAT_HIGH = 3'b100;

    localparam int N_BFAULT = 4;

    // boost fault flags, highest priority first
    typedef struct packed {
        logic out_ov;
        logic bat_high;
        logic bat_low;
        logic overload;
    } bfault_t;

endpackage

// File: rtl/ovl_qualifier.sv
module ovl_qualifier #(
    parameter int HOLD_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flag,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!arm || !flag) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        expired = arm && flag && tick && (cnt_q == LAST);
    end

endmodule

// File: rtl/bfault_encoder.sv
module bfault_encoder
    import conv_mode_pkg::*;
(
    input  bfault_t        flags,
    output logic [FC_W-1:0] code,
    output logic            any
);
    logic [N_BFAULT-1:0]   vec;
    logic [FC_W-1:0]       lut [N_BFAULT];

    assign vec = flags;

    always_comb begin
        lut[3] = FC_OUT_OV;
        lut[2] = FC_BAT_HIGH;
        lut[1] = FC_BAT_LOW;
        lut[0] = FC_OVERLOAD;
    end

    // lowest index scanned first so the highest set bit wins last
    always_comb begin
        code = FC_NONE;
        for (int i = 0; i < N_BFAULT; i++) begin
            if (vec[i]) begin
                code = lut[i];
            end
        end
        any = |vec;
    end

endmodule

// File: rtl/fault_pulse_gen.sv
module fault_pulse_gen #(
    parameter int PULSE_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (fire) begin
            cnt_q <= LOAD;
        end
    end

    always_comb begin
        active = (cnt_q != '0);
    end

endmodule

// File: rtl/conv_mode_ctrl.sv
module conv_mode_ctrl
    import conv_mode_pkg::*;
#(
    parameter int OVL_HOLD_TICKS = 30,
    parameter int PULSE_CYCLES   = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_1k,
    input  logic       mode_bit,
    input  logic       hiz_bit,
    input  logic       chg_dis,
    input  logic       otg_pin,
    input  logic       otg_pin_pol,
    input  logic       otg_use_en,
    input  logic       vin_uvlo,
    input  logic       chg_fault,
    input  logic       status_en,
    input  logic       flt_clr,
    input  logic       bst_out_ov,
    input  logic       bst_overload,
    input  logic       bst_bat_high,
    input  logic       bst_bat_low,
    output logic [1:0] op_mode,
    output logic       mode_clr_req,
    output logic       boost_stat,
    output logic [2:0] fault_code,
    output logic       stat_n
);
    opmode_e         state_q, state_d;
    logic [FC_W-1:0] code_q;
    logic            clr_pend_q;
    logic            ovl_lock_q;
    logic            chg_fault_q;

    logic            force_hiz, otg_active, boost_want, inst_fault;
    logic            in_boost, ovl_expired, bf_any, bf_evt, pulse_fire, pulse_on;
    logic [FC_W-1:0] bf_code;
    bfault_t         bf_flags;
    opmode_e         charge_pick;

    assign in_boost   = (state_q == MD_BOOST);
    assign force_hiz  = hiz_bit | chg_dis;
    assign otg_active = otg_use_en & (otg_pin == otg_pin_pol);
    assign boost_want = (mode_bit & ~clr_pend_q) | otg_active;
    assign inst_fault = bst_out_ov | bst_bat_high | bst_bat_low;

    ovl_qualifier #(.HOLD_TICKS(OVL_HOLD_TICKS)) u_ovl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (in_boost),
        .flag    (bst_overload),
        .tick    (tick_1k),
        .expired (ovl_expired)
    );

    always_comb begin
        bf_flags.out_ov   = bst_out_ov;
        bf_flags.bat_high = bst_bat_high;
        bf_flags.bat_low  = bst_bat_low;
        bf_flags.overload = ovl_expired;
    end

    bfault_encoder u_enc (
        .flags (bf_flags),
        .code  (bf_code),
        .any   (bf_any)
    );

    assign bf_evt     = in_boost & ~force_hiz & bf_any;
    assign pulse_fire = bf_evt | (chg_fault & ~chg_fault_q);

    fault_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (pulse_fire),
        .active (pulse_on)
    );

    // charge_select
    always_comb begin
        if (vin_uvlo) begin
            charge_pick = MD_HIZ;
        end else if (chg_fault || code_q != FC_NONE) begin
            charge_pick = MD_CFG;
        end else begin
            charge_pick = MD_CHARGE;
        end
    end

    // next-state
    always_comb begin
        state_d = state_q;
        if (force_hiz) begin
            state_d = MD_HIZ;
        end else begin
            unique case (state_q)
                MD_BOOST: begin
                    if (bf_any) begin
                        state_d = vin_uvlo ? MD_HIZ : MD_CFG;
                    end else if (!boost_want) begin
                        state_d = charge_pick;
                    end
                end
                MD_HIZ, MD_CHARGE, MD_CFG: begin
                    if (boost_want && !ovl_lock_q && !inst_fault) begin
                        state_d = MD_BOOST;
                    end else begin
                        state_d = charge_pick;
                    end
                end
            endcase
        end
    end

    // state register and fault bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= MD_HIZ;
            code_q      <= FC_NONE;
            clr_pend_q  <= 1'b0;
            ovl_lock_q  <= 1'b0;
            chg_fault_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            chg_fault_q <= chg_fault;
            if (bf_evt) begin
                code_q <= bf_code;
            end else if (flt_clr) begin
                code_q <= FC_NONE;
            end
            if (bf_evt && bf_code == FC_OVERLOAD) begin
                ovl_lock_q <= 1'b1;
            end else if (flt_clr) begin
                ovl_lock_q <= 1'b0;
            end
            if (bf_evt) begin
                clr_pend_q <= 1'b1;
            end else if (!mode_bit) begin
                clr_pend_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        op_mode      = state_q;
        boost_stat   = in_boost;
        fault_code   = code_q;
        mode_clr_req = clr_pend_q;
        stat_n       = ~(pulse_on | ((state_q == MD_CHARGE) & status_en));
    end

endmodule

// File: rtl/conv_mode_ctrl_chk.sv
module conv_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_bit,
    input logic       hiz_bit,
    input logic       chg_dis,
    input logic       otg_use_en,
    input logic       vin_uvlo,
    input logic       status_en,
    input logic       bst_out_ov,
    input logic       bst_bat_high,
    input logic       bst_bat_low,
    input logic [1:0] op_mode,
    input logic       mode_clr_req,
    input logic [2:0] fault_code,
    input logic       stat_n
);
    p_hiz_force_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hiz_bit || chg_dis) |=> (op_mode == 2'b00));

    p_uvlo_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hiz_bit && !chg_dis && vin_uvlo && !mode_bit && !otg_use_en && op_mode != 2'b11)
        |=> (op_mode == 2'b00));

    p_fault_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11 && !hiz_bit && !chg_dis && (bst_out_ov || bst_bat_high || bst_bat_low))
        |=> (op_mode != 2'b11 && mode_clr_req));

    p_ovp_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b11 && !hiz_bit && !chg_dis && bst_out_ov) |=> (fault_code == 3'b001));

    p_clr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clr_req && mode_bit) |=> mode_clr_req);

    p_ovl_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_code == 3'b010 && op_mode != 2'b11) |=> (op_mode != 2'b11));

    p_charge_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 2'b01 && status_en) |-> !stat_n);

endmodule

bind conv_mode_ctrl conv_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_bit     (mode_bit),
    .hiz_bit      (hiz_bit),
    .chg_dis      (chg_dis),
    .otg_use_en   (otg_use_en),
    .vin_uvlo     (vin_uvlo),
    .status_en    (status_en),
    .bst_out_ov   (bst_out_ov),
    .bst_bat_high (bst_bat_high),
    .bst_bat_low  (bst_bat_low),
    .op_mode      (op_mode),
    .mode_clr_req (mode_clr_req),
    .fault_code   (fault_code),
    .stat_n       (stat_n)
);

// File: tb/conv_mode_ctrl_tb.sv
module conv_mode_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    localparam logic [1:0] HIZ = 2'b00, CHG = 2'b01, CFG = 2'b10, BST = 2'b11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1k = 0, mode_bit = 0, hiz_bit = 0, chg_dis = 0;
    logic otg_pin = 0, otg_pin_pol = 0, otg_use_en = 0, vin_uvlo = 0;
    logic chg_fault = 0, status_en = 1, flt_clr = 0;
    logic bst_out_ov = 0, bst_overload = 0, bst_bat_high = 0, bst_bat_low = 0;
    logic [1:0] op_mode;
    logic       mode_clr_req, boost_stat, stat_n;
    logic [2:0] fault_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_mode_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k), .mode_bit(mode_bit),
        .hiz_bit(hiz_bit), .chg_dis(chg_dis), .otg_pin(otg_pin),
        .otg_pin_pol(otg_pin_pol), .otg_use_en(otg_use_en), .vin_uvlo(vin_uvlo),
        .chg_fault(chg_fault), .status_en(status_en), .flt_clr(flt_clr),
        .bst_out_ov(bst_out_ov), .bst_overload(bst_overload),
        .bst_bat_high(bst_bat_high), .bst_bat_low(bst_bat_low),
        .op_mode(op_mode), .mode_clr_req(mode_clr_req), .boost_stat(boost_stat),
        .fault_code(fault_code), .stat_n(stat_n)
    );

    typedef struct {
        string      tag;
        logic [1:0] m;
        logic [2:0] c;
        logic       r;
        logic       s;
        bit         cs;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;

    // monitor: pops expected items and compares with the ports
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (op_mode !== e.m || boost_stat !== (e.m == BST) || fault_code !== e.c ||
                    mode_clr_req !== e.r || (e.cs && stat_n !== e.s)) begin
                    n_bad++;
                    $display("FAIL %s: got mode=%b boost=%b code=%b clr=%b stat_n=%b, exp mode=%b boost=%b code=%b clr=%b stat_n=%b(%0d)",
                             e.tag, op_mode, boost_stat, fault_code, mode_clr_req, stat_n,
                             e.m, (e.m == BST), e.c, e.r, e.s, e.cs);
                end
            end
        end
    end

    task automatic expect_out(input string tag, input logic [1:0] m, input logic [2:0] c,
                              input logic r, input logic s, input bit cs);
        exp_t e;
        e.tag = tag; e.m = m; e.c = c; e.r = r; e.s = s; e.cs = cs;
        q.push_back(e);
        ->chk_ev;
        #0;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic one_tick();
        tick_1k = 1; cyc(); tick_1k = 0; cyc();
    endtask

    // host clears bit and fault register, then waits out any pulse
    task automatic recover(input logic [2:0] code);
        bst_out_ov = 0; bst_bat_high = 0; bst_bat_low = 0; bst_overload = 0;
        mode_bit = 0; cyc();
        expect_out("R7 clr drops once mode bit is 0", CFG, code, 0, 0, 0);
        flt_clr = 1; cyc();
        expect_out("R8 flt_clr zeroes code", CFG, 3'b000, 0, 0, 0);
        flt_clr = 0;
        repeat (130) cyc();
        expect_out("R3 back to CHARGE after clear", CHG, 3'b000, 0, 1, 1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements): run did not complete, exp done=1 got 0");
            finish_run();
        end
    end

    initial begin
        // R1 reset state
        cyc(); cyc();
        expect_out("R1 reset", HIZ, 3'b000, 0, 1, 1);
        rst_n = 1; cyc();
        expect_out("R3 R9 charge with status low", CHG, 3'b000, 0, 0, 1);
        status_en = 0; cyc();
        expect_out("R9 status released when disabled", CHG, 3'b000, 0, 1, 1);

        // R2 forcing
        hiz_bit = 1; mode_bit = 1; cyc();
        expect_out("R2 hiz bit beats mode bit", HIZ, 3'b000, 0, 1, 1);
        hiz_bit = 0; chg_dis = 1; cyc();
        expect_out("R2 charge-disable pin", HIZ, 3'b000, 0, 1, 1);
        chg_dis = 0; mode_bit = 0; cyc();
        expect_out("R3 leaves HIZ", CHG, 3'b000, 0, 1, 1);

        // R3 undervoltage
        vin_uvlo = 1; cyc();
        expect_out("R3 uvlo gives HIZ", HIZ, 3'b000, 0, 1, 1);
        vin_uvlo = 0; cyc();
        expect_out("R3 uvlo gone", CHG, 3'b000, 0, 1, 1);

        // R10 pulse length and no retrigger, R3 charge-configure
        for (int i = 0; i < 200; i++) begin
            chg_fault = (i < 20 || i >= 50);
            cyc();
            expect_out("R10 R3 fault pulse", chg_fault ? CFG : CHG, 3'b000, 0,
                       (i < 128) ? 1'b0 : 1'b1, 1);
        end
        chg_fault = 0; cyc();
        expect_out("R3 fault cleared", CHG, 3'b000, 0, 1, 1);

        // R4 boost requests
        mode_bit = 1; cyc();
        expect_out("R4 mode bit boost", BST, 3'b000, 0, 1, 1);
        mode_bit = 0; cyc();
        expect_out("R4 boost release", CHG, 3'b000, 0, 1, 1);
        otg_use_en = 1; otg_pin_pol = 1; otg_pin = 1; cyc();
        expect_out("R4 otg active high", BST, 3'b000, 0, 1, 1);
        otg_pin = 0; cyc();
        expect_out("R4 otg inactive", CHG, 3'b000, 0, 1, 1);
        otg_use_en = 0; otg_pin = 1; cyc();
        expect_out("R4 otg disabled ignored", CHG, 3'b000, 0, 1, 1);
        otg_use_en = 1; otg_pin_pol = 0; otg_pin = 0; cyc();
        expect_out("R4 otg active low", BST, 3'b000, 0, 1, 1);
        otg_use_en = 0; otg_pin = 0; cyc();
        expect_out("R4 otg released", CHG, 3'b000, 0, 1, 1);

        // R5 R7 immediate fault, priority ovp over low battery
        mode_bit = 1; cyc();
        expect_out("R4 boost again", BST, 3'b000, 0, 1, 1);
        bst_out_ov = 1; bst_bat_low = 1; cyc();
        expect_out("R5 ovp wins, R7 clr", CFG, 3'b001, 1, 0, 1);
        bst_out_ov = 0; bst_bat_low = 0;
        repeat (3) cyc();
        expect_out("R7 stale mode bit ignored", CFG, 3'b001, 1, 0, 1);
        recover(3'b001);

        // R5 battery high beats battery low
        mode_bit = 1; cyc();
        expect_out("R4 boost", BST, 3'b000, 0, 1, 1);
        bst_bat_high = 1; bst_bat_low = 1; cyc();
        expect_out("R5 battery high code", CFG, 3'b100, 1, 0, 1);
        recover(3'b100);

        mode_bit = 1; cyc();
        expect_out("R4 boost", BST, 3'b000, 0, 1, 1);
        bst_bat_low = 1; cyc();
        expect_out("R5 battery low code", CFG, 3'b011, 1, 0, 1);
        recover(3'b011);

        // R5 entry blocked by present flag
        bst_bat_low = 1; mode_bit = 1; cyc();
        expect_out("R5 entry blocked", CHG, 3'b000, 0, 1, 1);
        bst_bat_low = 0; cyc();
        expect_out("R5 entry after flag clears", BST, 3'b000, 0, 1, 1);

        // R6 overload qualification
        bst_overload = 1;
        for (int k = 0; k < 20; k++) begin
            one_tick();
            expect_out("R6 overload not yet fault", BST, 3'b000, 0, 1, 1);
        end
        bst_overload = 0; cyc();
        expect_out("R6 flag dropped", BST, 3'b000, 0, 1, 1);
        bst_overload = 1;
        for (int k = 0; k < 29; k++) begin
            one_tick();
            expect_out("R6 restarted count below limit", BST, 3'b000, 0, 1, 1);
        end
        tick_1k = 1; cyc(); tick_1k = 0;
        expect_out("R6 overload fault on 30th tick", CFG, 3'b010, 1, 0, 1);

        // R8 overload block
        bst_overload = 0; mode_bit = 0; cyc();
        expect_out("R7 clr dropped", CFG, 3'b010, 0, 0, 1);
        mode_bit = 1;
        repeat (3) cyc();
        expect_out("R8 boost blocked after overload", CFG, 3'b010, 0, 0, 1);
        flt_clr = 1; cyc();
        expect_out("R8 clear accepted", CFG, 3'b000, 0, 0, 1);
        flt_clr = 0; cyc();
        expect_out("R8 boost allowed after clear", BST, 3'b000, 0, 0, 1);

        // R2 force from boost
        chg_dis = 1; cyc();
        expect_out("R2 pin forces HIZ from boost", HIZ, 3'b000, 0, 0, 0);

        cyc();
        finish_run();
    end

endmodule